// File: doc/BRIEF.md
# Audio Sample-Rate Clock Generator

This block produces a family of audio clocks from one fast master clock. Every output is a flop output, or a flop output chosen by a static strap. The block is clocked at twice the top audio rate, which is 768 or 1024 times the sample rate. The top output toggles on every clock, so it runs at the master rate of 384fs or 512fs. The other outputs are divided from it: half rate, 128fs, 64fs (bit clock), 32fs, 2fs and 1fs (word clock). The quarter-ratio strap decides whether the step from the master rate down to 128fs divides by three or by four. In both cases the result is 128fs.

A phase machine produces the 128fs output and a one-cycle period-end strobe. Its states are PH0 through PH7, and it steps PH0→PH1→…→PH5. From PH5 it returns to PH0 when the ratio is one third, or goes on through PH6→PH7→PH0 when the ratio is one quarter. The 128fs output is high in states PH4 and above. A binary counter advances once per period-end strobe, and its taps give the 64fs, 32fs, 2fs and word clock outputs.

The source strap selects between internal and external-sync operation. When it is low, the bit clock and word clock inputs pass through a two-flop synchronizer. The synchronized bit clock and word clock then drive the 64fs and word outputs, and the 32fs and 2fs outputs are counted from rising edges of the synchronized bit clock. Any change of the ratio strap clears the whole chain, so that all outputs restart in phase.

Top module: `fs_clock_tree`

## Requirements
- R1: `fs_top` is 0 in reset, is 1 in the first cycle after reset, and toggles every clock (period 2 clocks, high 1).
- R2: `fs_half` has a period of 4 clocks and is high for 2, changing only in cycles after `fs_top` was 1.
- R3: With `ratio_quarter`=0, `fs_128` has a period of 6 clocks and is high for 2 (one master period high, two low).
- R4: With `ratio_quarter`=1, `fs_128` has a period of 8 clocks and is high for 4.
- R5: With `src_internal`=1, `fs_64` has twice the period of `fs_128` (50% duty), and `fs_32` has twice the period of `fs_64`.
- R6: With `src_internal`=1, `fs_word` has a period of 128 `fs_128` periods at 50% duty. It starts low (left channel first) and first rises 64 `fs_128` periods after the chain is released.
- R7: With `src_internal`=1, `fs_2` has a period of 64 `fs_128` periods at 50% duty.
- R8: With `src_internal`=0, `fs_64` equals `bck_in` and `fs_word` equals `lrck_in`, each delayed by exactly two clocks.
- R9: With `src_internal`=0, `fs_32` toggles once per synchronized rising edge of `bck_in`, and `fs_2` toggles once per 16 such edges (after 15 rises from a cleared chain it is 0, after 16 it is 1).
- R10: A change of `ratio_quarter` clears the chain. In the following cycle all seven outputs are 0, and `fs_word` then first rises 64 periods of the new `fs_128` later.
- R11: While `rst` is high, all seven outputs are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the 384/512fs master rate |
| rst | input | 1 | Synchronous active-high reset |
| ratio_quarter | input | 1 | Master-to-128fs ratio: 0 divides by three, 1 divides by four |
| src_internal | input | 1 | 1: all clocks divided internally; 0: bit and word clocks follow the inputs |
| bck_in | input | 1 | External bit clock (64fs) |
| lrck_in | input | 1 | External word clock (1fs) |
| fs_top | output | 1 | 384/512fs clock |
| fs_half | output | 1 | 192/256fs clock |
| fs_128 | output | 1 | 128fs clock |
| fs_64 | output | 1 | 64fs bit clock |
| fs_32 | output | 1 | 32fs clock |
| fs_2 | output | 1 | 2fs clock |
| fs_word | output | 1 | 1fs word clock |

## Verification
The internal chain is tested with the one-third ratio, then the one-quarter ratio, then the one-third ratio again. At each setting every output's period and high time is measured, which shows whether a stage picks the wrong ratio, the wrong counter tap or the wrong duty cycle. Counting cycles from reset release, and from a ratio change, to the first word-clock rise shows whether the chain really clears and whether the left channel comes first. In external-sync mode, single steps of the bit and word clock inputs check the exact two-cycle latency, and a counted burst of 16 bit-clock rises separates the 32fs and 2fs taps from neighbouring bits.

// File: rtl/fsclk_pkg.sv
package fsclk_pkg;
    // Phase of the master-to-128fs prescaler
    typedef enum logic [2:0] {
        PH0 = 3'd0, PH1 = 3'd1, PH2 = 3'd2, PH3 = 3'd3,
        PH4 = 3'd4, PH5 = 3'd5, PH6 = 3'd6, PH7 = 3'd7
    } phase_e;

    // Phases at or above this one drive the 128fs output high
    localparam phase_e HIGH_FROM = PH4;
endpackage

// File: rtl/fsclk_prescale.sv
module fsclk_prescale
    import fsclk_pkg::*;
(
    input  logic clk,
    input  logic clr,
    input  logic ratio4,
    output logic fs128,
    output logic per_end
);
    phase_e st_q;
    phase_e st_d;
    phase_e last_ph;

    assign last_ph = ratio4 ? PH7 : PH5;

    // State register
    always_ff @(posedge clk) begin
        if (clr) st_q <= PH0;
        else     st_q <= st_d;
    end

    // Next state
    always_comb begin
        st_d = PH0;
        unique case (st_q)
            PH0: st_d = PH1;
            PH1: st_d = PH2;
            PH2: st_d = PH3;
            PH3: st_d = PH4;
            PH4: st_d = PH5;
            PH5: st_d = ratio4 ? PH6 : PH0;
            PH6: st_d = PH7;
            PH7: st_d = PH0;
        endcase
    end

    // Registered outputs, aligned with the state register
    always_ff @(posedge clk) begin
        if (clr) begin
            fs128   <= 1'b0;
            per_end <= 1'b0;
        end else begin
            fs128   <= (st_d >= HIGH_FROM);
            per_end <= (st_d == last_ph);
        end
    end

    // Clear history so that $past never reaches before a clear
    logic [3:0] hist;
    logic       hold;
    always_ff @(posedge clk) hist <= {hist[2:0], clr};
    assign hold = clr | (|hist);

    assert_third_high_R3: assert property (@(posedge clk) disable iff (hold)
        (!ratio4 && $fell(fs128)) |-> ($past(fs128, 2) && !$past(fs128, 3)));

    assert_quarter_high_R4: assert property (@(posedge clk) disable iff (hold)
        (ratio4 && $fell(fs128)) |-> $past(fs128, 4));

    assert_end_single_R3: assert property (@(posedge clk) disable iff (hold)
        per_end |=> !per_end);
endmodule

// File: rtl/fsclk_sync.sv
module fsclk_sync #(
    parameter int W      = 2,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) stg[i] <= '0;
        end else begin
            stg[0] <= d;
            for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
        end
    end

    assign q = stg[STAGES-1];

    generate
        if (STAGES == 2) begin : g_chk
            logic [1:0] rh;
            always_ff @(posedge clk) rh <= {rh[0], rst};
            assert_sync_delay_R8: assert property (@(posedge clk)
                disable iff (rst || rh[0] || rh[1]) q == $past(d, 2));
        end
    endgenerate
endmodule

// File: rtl/fsclk_ratediv.sv
module fsclk_ratediv #(
    parameter int DIV_W   = 7,
    parameter int FS2_TAP = 5,
    parameter int EXT_W   = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic step,
    input  logic bck_s,
    output logic div64,
    output logic div32,
    output logic div2,
    output logic divword,
    output logic ext32,
    output logic ext2
);
    logic [DIV_W-1:0] div_q;
    logic [EXT_W-1:0] ext_q;
    logic             bck_p;

    // Internal chain: one count per 128fs period
    always_ff @(posedge clk) begin
        if (clr)       div_q <= '0;
        else if (step) div_q <= div_q + 1'b1;
    end

    // External chain: one count per synchronized bit-clock rise
    always_ff @(posedge clk) begin
        if (clr) begin
            ext_q <= '0;
            bck_p <= bck_s;
        end else begin
            bck_p <= bck_s;
            if (bck_s && !bck_p) ext_q <= ext_q + 1'b1;
        end
    end

    assign div64   = div_q[0];
    assign div32   = div_q[1];
    assign div2    = div_q[FS2_TAP];
    assign divword = div_q[DIV_W-1];
    assign ext32   = ext_q[0];
    assign ext2    = ext_q[EXT_W-1];

    logic clr_h;
    always_ff @(posedge clk) clr_h <= clr;

    assert_div_step_R5: assert property (@(posedge clk) disable iff (clr || clr_h)
        (div_q != $past(div_q)) |-> $past(step));

    assert_ext_step_R9: assert property (@(posedge clk) disable iff (clr || clr_h)
        (ext_q != $past(ext_q)) |-> $past(bck_s && !bck_p));
endmodule

// File: rtl/fs_clock_tree.sv
module fs_clock_tree #(
    parameter int WORD_LOG2   = 7,
    parameter int FS2_LOG2    = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ratio_quarter,
    input  logic src_internal,
    input  logic bck_in,
    input  logic lrck_in,
    output logic fs_top,
    output logic fs_half,
    output logic fs_128,
    output logic fs_64,
    output logic fs_32,
    output logic fs_2,
    output logic fs_word
);
    localparam int FS2_TAP = FS2_LOG2 - 1;
    localparam int EXT_W   = FS2_LOG2 - 1;

    logic ratio_q;
    logic clr;
    logic per_end;
    logic bck_s, lrck_s;
    logic div64, div32, div2, divword, ext32, ext2;

    // Ratio strap tracking: any change clears the chain
    always_ff @(posedge clk) ratio_q <= ratio_quarter;
    assign clr = rst | (ratio_q != ratio_quarter);

    // Master and half-rate stages
    always_ff @(posedge clk) begin
        if (clr) begin
            fs_top  <= 1'b0;
            fs_half <= 1'b0;
        end else begin
            fs_top  <= ~fs_top;
            if (fs_top) fs_half <= ~fs_half;
        end
    end

    fsclk_prescale u_pre (
        .clk     (clk),
        .clr     (clr),
        .ratio4  (ratio_q),
        .fs128   (fs_128),
        .per_end (per_end)
    );

    fsclk_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({lrck_in, bck_in}),
        .q   ({lrck_s, bck_s})
    );

    fsclk_ratediv #(.DIV_W(WORD_LOG2), .FS2_TAP(FS2_TAP), .EXT_W(EXT_W)) u_div (
        .clk     (clk),
        .clr     (clr),
        .step    (per_end),
        .bck_s   (bck_s),
        .div64   (div64),
        .div32   (div32),
        .div2    (div2),
        .divword (divword),
        .ext32   (ext32),
        .ext2    (ext2)
    );

    // Static strap picks the source for the bit-clock family
    always_comb begin
        if (src_internal) begin
            fs_64   = div64;
            fs_32   = div32;
            fs_2    = div2;
            fs_word = divword;
        end else begin
            fs_64   = bck_s;
            fs_32   = ext32;
            fs_2    = ext2;
            fs_word = lrck_s;
        end
    end

    logic clr_h;
    always_ff @(posedge clk) clr_h <= clr;

    assert_top_toggle_R1: assert property (@(posedge clk) disable iff (clr || clr_h)
        fs_top != $past(fs_top));

    assert_half_step_R2: assert property (@(posedge clk) disable iff (clr || clr_h)
        (fs_half != $past(fs_half)) |-> $past(fs_top));

    assert_clear_zero_R10: assert property (@(posedge clk)
        clr |=> (!fs_top && !fs_half && !fs_128));
endmodule

// File: tb/fs_clock_tree_tb_top.sv
module fs_clock_tree_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int WD_CYCLES  = 150000;

    typedef struct packed {
        logic ratio;
        int   p128;
        int   h128;
    } vec_t;

    localparam vec_t VEC [3] = '{
        '{1'b0, 6, 2},
        '{1'b1, 8, 4},
        '{1'b0, 6, 2}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ratio_quarter = 1'b0;
    logic src_internal = 1'b1;
    logic bck_in = 1'b0;
    logic lrck_in = 1'b0;
    logic fs_top, fs_half, fs_128, fs_64, fs_32, fs_2, fs_word;
    logic [6:0] obs;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    fs_clock_tree dut_i (
        .clk           (clk),
        .rst           (rst),
        .ratio_quarter (ratio_quarter),
        .src_internal  (src_internal),
        .bck_in        (bck_in),
        .lrck_in       (lrck_in),
        .fs_top        (fs_top),
        .fs_half       (fs_half),
        .fs_128        (fs_128),
        .fs_64         (fs_64),
        .fs_32         (fs_32),
        .fs_2          (fs_2),
        .fs_word       (fs_word)
    );

    assign obs = {fs_word, fs_2, fs_32, fs_64, fs_128, fs_half, fs_top};

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Period and high time of obs[idx], from one rising edge to the next
    task automatic measure(input int idx, output int per, output int hi);
        logic prev;
        per = 0;
        hi  = 0;
        while (obs[idx] !== 1'b0) @(negedge clk);
        while (obs[idx] !== 1'b1) @(negedge clk);
        while (1) begin
            if (obs[idx]) hi++;
            per++;
            prev = obs[idx];
            @(negedge clk);
            if (obs[idx] && !prev) break;
        end
    endtask

    task automatic bck_rise();
        @(negedge clk) bck_in = 1'b1;
        repeat (3) @(negedge clk);
        bck_in = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        int per, hi, n;
        // R11: outputs held at zero in reset
        repeat (3) @(negedge clk);
        chk("R11 reset outputs", int'(obs), 0);

        // R1 / R6: release and count to the first word-clock rise
        rst = 1'b0;
        @(negedge clk);
        chk("R1 first cycle top", int'(fs_top), 1);
        n = 1;
        while (!fs_word) begin
            @(negedge clk);
            n++;
        end
        chk("R6 left-first start", n, 64 * 6);

        // Table of ratio settings in internal mode
        foreach (VEC[v]) begin
            @(negedge clk) ratio_quarter = VEC[v].ratio;
            repeat (3) @(negedge clk);
            measure(2, per, hi);
            chk(VEC[v].ratio ? "R4 fs_128 period" : "R3 fs_128 period", per, VEC[v].p128);
            chk(VEC[v].ratio ? "R4 fs_128 high" : "R3 fs_128 high", hi, VEC[v].h128);
            measure(3, per, hi);
            chk("R5 fs_64 period", per, 2 * VEC[v].p128);
            chk("R5 fs_64 high", hi, VEC[v].p128);
            measure(4, per, hi);
            chk("R5 fs_32 period", per, 4 * VEC[v].p128);
            measure(0, per, hi);
            chk("R1 fs_top period", per, 2);
            chk("R1 fs_top high", hi, 1);
            measure(1, per, hi);
            chk("R2 fs_half period", per, 4);
            chk("R2 fs_half high", hi, 2);
            measure(6, per, hi);
            chk("R6 fs_word period", per, 128 * VEC[v].p128);
            chk("R6 fs_word high", hi, 64 * VEC[v].p128);
            measure(5, per, hi);
            chk("R7 fs_2 period", per, 64 * VEC[v].p128);
            chk("R7 fs_2 high", hi, 32 * VEC[v].p128);
        end

        // R10: ratio change clears the whole chain
        repeat (5) @(negedge clk);
        ratio_quarter = 1'b1;
        @(negedge clk);
        chk("R10 cleared outputs", int'(obs), 0);
        n = 0;
        while (!fs_word) begin
            @(negedge clk);
            n++;
        end
        chk("R10 restart to word rise", n, 64 * 8);

        // R8 / R9: external-sync mode after a fresh clear
        @(negedge clk) ratio_quarter = 1'b0;
        src_internal = 1'b1;
        @(negedge clk);
        src_internal = 1'b0;
        @(negedge clk);
        chk("R9 fs_32 start", int'(fs_32), 0);
        bck_in = 1'b1;
        @(negedge clk);
        chk("R8 bck one cycle", int'(fs_64), 0);
        @(negedge clk);
        chk("R8 bck two cycles", int'(fs_64), 1);
        repeat (3) @(negedge clk);
        chk("R9 fs_32 after one rise", int'(fs_32), 1);
        bck_in = 1'b0;
        repeat (3) @(negedge clk);
        for (int i = 0; i < 14; i++) bck_rise();
        repeat (4) @(negedge clk);
        chk("R9 fs_2 after 15 rises", int'(fs_2), 0);
        chk("R9 fs_32 after 15 rises", int'(fs_32), 1);
        bck_rise();
        chk("R9 fs_2 after 16 rises", int'(fs_2), 1);
        chk("R9 fs_32 after 16 rises", int'(fs_32), 0);
        lrck_in = 1'b1;
        @(negedge clk);
        chk("R8 lrck one cycle", int'(fs_word), 0);
        @(negedge clk);
        chk("R8 lrck two cycles", int'(fs_word), 1);

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual timeout expected completion");
            $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
            $finish;
        end
    end
endmodule